// File: doc/BRIEF.md
# Spare-Column Shift Repair Network

This block is a row of identical registered processing cells with one extra spare cell at the high end. A fault map names at most one physical column as bad. Steering multiplexers on the input side and on the output side move every logical lane at or above the bad column one physical position toward the spare. The lanes seen by the user therefore keep their numbering and their function after a repair.

Each cell adds a fixed constant to its operand and registers the sum, so every lane has one cycle of latency. The fault map is accepted only while the surrounding system holds `idle_i` high. A map that marks two or more columns cannot be repaired with a single spare. Such a map is refused, the unrepairable flag is raised, and the mapping in force stays as it was.

Top module: `srn_repair_top`

## Requirements
- R1: While and after reset, with no new map loaded, every result lane reads 0, `map_o` reads 0 and `unrep_o` reads 0.
- R2: With no column marked, result lane i equals lane input i plus INC (default 3), modulo 2^W, one clock after the input is sampled, every cycle, with no stall.
- R3: With only physical column f marked (bit f of the map; bit NL is the spare), lane i is carried by column i when i < f and by column i+1 otherwise, and every result lane still equals its input plus INC one cycle later.
- R4: The cell in a marked column drives the fixed pattern CORRUPT (default 8'hA5) in place of its sum, and that pattern never reaches a result lane unless the correct result happens to equal it.
- R5: `fmap_i` is sampled only on clock edges where `idle_i` is 1; with `idle_i` at 0, `map_o` and `unrep_o` hold their values.
- R6: A map with two or more bits set, sampled while idle, sets `unrep_o` to 1 at the next edge and leaves `map_o` and the lane mapping unchanged.
- R7: A map with zero or one bit set, sampled while idle, becomes `map_o` at the next edge and clears `unrep_o`.
- R8: Data sampled on the same edge that loads a new map is steered by the old map, so the result lanes stay correct on every cycle around a map change.
- R9: A map that is all zero, or that marks only the spare column, gives the straight mapping lane i to column i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | High when a new fault map may be taken |
| fmap_i | input | NL+1 | Candidate fault map, one bit per physical column, MSB is the spare |
| lane_d_i | input | NL*W | Logical lane operands, lane 0 in the low bits |
| lane_q_o | output | NL*W | Logical lane results, lane 0 in the low bits |
| map_o | output | NL+1 | Fault map in force |
| unrep_o | output | 1 | Last offered map was refused as unrepairable |

## Verification
The two functions that can coincide are a map load and the flow of lane data. When `idle_i` is high, the edge that installs a new bad column also samples operands into the cells. The bench provokes this by offering a fresh map (none, one column, the spare, or two columns) together with new random operands on many consecutive cycles. It judges the outcome by requiring every lane to equal its operand plus INC on the next cycle, while a reference model of the map and the flag tracks which offers were taken and which were refused.

// File: rtl/srn_pkg.sv
package srn_pkg;
  typedef enum logic [1:0] {
    LD_HOLD   = 2'd0,
    LD_APPLY  = 2'd1,
    LD_REJECT = 2'd2
  } srn_load_e;
endpackage

// File: rtl/srn_ctrl.sv
module srn_ctrl
  import srn_pkg::*;
#(
  parameter int NL = 8,
  localparam int NCOL = NL + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            idle_i,
  input  logic [NCOL-1:0] fmap_i,
  output logic [NCOL-1:0] map_o,
  output logic            unrep_o,
  output logic [NL-1:0]   shift_o
);
  logic [NCOL-1:0] map_q;
  logic            unrep_q;
  logic            multi;
  srn_load_e       ld;

  assign multi = (fmap_i & (fmap_i - NCOL'(1))) != '0;

  always_comb begin
    if (!idle_i)    ld = LD_HOLD;
    else if (multi) ld = LD_REJECT;
    else            ld = LD_APPLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= '0;
      unrep_q <= 1'b0;
    end else begin
      case (ld)
        LD_APPLY: begin
          map_q   <= fmap_i;
          unrep_q <= 1'b0;
        end
        LD_REJECT: unrep_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // lane i moves up once the bad column is at or below i
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NL; i++) begin
      acc        = acc | map_q[i];
      shift_o[i] = acc;
    end
  end

  assign map_o   = map_q;
  assign unrep_o = unrep_q;
endmodule

// File: rtl/srn_in_steer.sv
module srn_in_steer #(
  parameter int NL = 8,
  parameter int W  = 8,
  localparam int NCOL = NL + 1
) (
  input  logic [NL*W-1:0]   lane_i,
  input  logic [NL-1:0]     shift_i,
  output logic [NCOL*W-1:0] col_o
);
  for (genvar p = 0; p < NCOL; p++) begin : g_col
    logic take_own, take_low;
    if (p < NL) begin : g_own
      assign take_own = !shift_i[p];
    end else begin : g_no_own
      assign take_own = 1'b0;
    end
    if (p > 0) begin : g_low
      assign take_low = shift_i[p-1];
    end else begin : g_no_low
      assign take_low = 1'b0;
    end
    always_comb begin
      col_o[p*W +: W] = '0;
      if (take_own)      col_o[p*W +: W] = lane_i[(p < NL ? p : 0)*W +: W];
      else if (take_low) col_o[p*W +: W] = lane_i[(p > 0 ? p-1 : 0)*W +: W];
    end
  end
endmodule

// File: rtl/srn_cell.sv
module srn_cell #(
  parameter int          W       = 8,
  parameter logic [W-1:0] INC     = W'(3),
  parameter logic [W-1:0] CORRUPT = W'(8'hA5)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         bad_i,
  output logic [W-1:0] res_o,
  output logic         bad_o
);
  logic [W-1:0] res_q;
  logic         bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      bad_q <= 1'b0;
    end else begin
      res_q <= d_i + INC;
      bad_q <= bad_i;
    end
  end

  assign res_o = bad_q ? CORRUPT : res_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/srn_out_steer.sv
module srn_out_steer #(
  parameter int NL = 8,
  parameter int W  = 8,
  localparam int NCOL = NL + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NL-1:0]     shift_i,
  input  logic [NCOL*W-1:0] col_i,
  output logic [NL*W-1:0]   lane_o,
  output logic [NL-1:0]     sel_o
);
  // select travels with the data it steered in
  logic [NL-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= shift_i;
  end

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lane_o[i*W +: W] = sel_q[i] ? col_i[(i+1)*W +: W] : col_i[i*W +: W];
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/srn_repair_top.sv
module srn_repair_top #(
  parameter int           NL      = 8,
  parameter int           W       = 8,
  parameter logic [W-1:0] INC     = W'(3),
  parameter logic [W-1:0] CORRUPT = W'(8'hA5),
  localparam int NCOL = NL + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic [NCOL-1:0]   fmap_i,
  input  logic [NL*W-1:0]   lane_d_i,
  output logic [NL*W-1:0]   lane_q_o,
  output logic [NCOL-1:0]   map_o,
  output logic              unrep_o
);
  logic [NL-1:0]     shift;
  logic [NL-1:0]     out_shift_q;
  logic [NCOL*W-1:0] col_d;
  logic [NCOL*W-1:0] col_q;
  logic [NCOL-1:0]   cell_bad_q;

  srn_ctrl #(.NL(NL)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (idle_i),
    .fmap_i  (fmap_i),
    .map_o   (map_o),
    .unrep_o (unrep_o),
    .shift_o (shift)
  );

  srn_in_steer #(.NL(NL), .W(W)) u_in (
    .lane_i  (lane_d_i),
    .shift_i (shift),
    .col_o   (col_d)
  );

  for (genvar p = 0; p < NCOL; p++) begin : g_cell
    srn_cell #(.W(W), .INC(INC), .CORRUPT(CORRUPT)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (col_d[p*W +: W]),
      .bad_i  (map_o[p]),
      .res_o  (col_q[p*W +: W]),
      .bad_o  (cell_bad_q[p])
    );
  end

  srn_out_steer #(.NL(NL), .W(W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .col_i   (col_q),
    .lane_o  (lane_q_o),
    .sel_o   (out_shift_q)
  );
endmodule

// File: rtl/srn_repair_chk.sv
module srn_repair_chk #(
  parameter int           NL  = 8,
  parameter int           W   = 8,
  parameter logic [W-1:0] INC = W'(3),
  localparam int NCOL = NL + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idle_i,
  input logic [NCOL-1:0]   fmap_i,
  input logic [NL*W-1:0]   lane_d_i,
  input logic [NL*W-1:0]   lane_q_o,
  input logic [NCOL-1:0]   map_o,
  input logic              unrep_o,
  input logic [NCOL-1:0]   cell_bad_q,
  input logic [NL-1:0]     out_shift_q
);
  logic ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= 1'b1;
  end

  a_r5_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(map_o) && $stable(unrep_o));

  a_r6_reject_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && ($countones(fmap_i) > 1) |=> unrep_o && (map_o == $past(map_o)));

  a_r7_accept_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && ($countones(fmap_i) <= 1) |=> !unrep_o && (map_o == $past(fmap_i)));

  for (genvar i = 0; i < NL; i++) begin : g_lane
    a_r2_lane_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ok_q |-> lane_q_o[i*W +: W] == W'($past(lane_d_i[i*W +: W]) + INC));

    // R4: the column feeding a lane never carries the bad flag
    a_r4_no_bad_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(out_shift_q[i] ? cell_bad_q[i+1] : cell_bad_q[i]));
  end
endmodule

bind srn_repair_top srn_repair_chk #(.NL(NL), .W(W), .INC(INC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idle_i      (idle_i),
  .fmap_i      (fmap_i),
  .lane_d_i    (lane_d_i),
  .lane_q_o    (lane_q_o),
  .map_o       (map_o),
  .unrep_o     (unrep_o),
  .cell_bad_q  (cell_bad_q),
  .out_shift_q (out_shift_q)
);

// File: tb/srn_repair_top_bench.sv
module srn_repair_top_bench;
  localparam int NL   = 8;
  localparam int W    = 8;
  localparam int NCOL = NL + 1;
  localparam logic [W-1:0] INC = 8'd3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              idle = 1'b0;
  logic [NCOL-1:0]   fmap = '0;
  logic [NL*W-1:0]   lane_d = '0;
  logic [NL*W-1:0]   lane_q;
  logic [NCOL-1:0]   map_q;
  logic              unrep;

  int n_chk = 0;
  int n_err = 0;
  logic [NCOL-1:0] r_map = '0;
  logic            r_unrep = 1'b0;

  always #4 clk = ~clk;

  srn_repair_top u_srn_repair_top (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .idle_i   (idle),
    .fmap_i   (fmap),
    .lane_d_i (lane_d),
    .lane_q_o (lane_q),
    .map_o    (map_q),
    .unrep_o  (unrep)
  );

  function automatic logic [NL*W-1:0] exp_lanes(input logic [NL*W-1:0] d);
    logic [NL*W-1:0] r;
    for (int i = 0; i < NL; i++) r[i*W +: W] = d[i*W +: W] + INC;
    return r;
  endfunction

  function automatic logic [NL*W-1:0] rnd_d();
    logic [NL*W-1:0] r;
    for (int i = 0; i < NL; i++) begin
      logic [W-1:0] b;
      b = W'($urandom);
      if (b == 8'hA2) b = 8'hA3;  // keep expected results away from CORRUPT
      r[i*W +: W] = b;
    end
    return r;
  endfunction

  function automatic logic [NCOL-1:0] rnd_map();
    logic [NCOL-1:0] m;
    int k, a, b;
    m = '0;
    k = $urandom % 4;
    a = $urandom % NCOL;
    b = (a + 1 + ($urandom % (NCOL - 1))) % NCOL;
    if (k == 1 || k == 2) m[a] = 1'b1;
    else if (k == 3) begin m[a] = 1'b1; m[b] = 1'b1; end
    return m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, check at the following negedge
  task automatic cyc(input logic [NL*W-1:0] d, input logic idl,
                     input logic [NCOL-1:0] fm, input string req);
    lane_d = d;
    idle   = idl;
    fmap   = fm;
    @(posedge clk);
    if (idl) begin
      if ($countones(fm) > 1) r_unrep = 1'b1;
      else begin r_map = fm; r_unrep = 1'b0; end
    end
    @(negedge clk);
    chk({req, " lanes"}, 64'(lane_q), 64'(exp_lanes(d)));
    chk({req, " map"},   64'(map_q),  64'(r_map));
    chk({req, " flag"},  64'(unrep),  64'(r_unrep));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 lanes", 64'(lane_q), 64'd0);
    chk("R1 map",   64'(map_q),  64'd0);
    chk("R1 flag",  64'(unrep),  64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 64'(map_q), 64'd0);

    // R2: no fault, random data, busy
    for (int n = 0; n < 20; n++) cyc(rnd_d(), 1'b0, '0, "R2");

    // R3/R4: each single column including the spare (R9)
    for (int f = 0; f < NCOL; f++) begin
      logic [NCOL-1:0] m;
      m = '0;
      m[f] = 1'b1;
      cyc(rnd_d(), 1'b1, m, f == NL ? "R9" : "R7");
      for (int n = 0; n < 6; n++) cyc(rnd_d(), 1'b0, '0, "R3");
      cyc({NL{8'hFD}}, 1'b0, '0, "R4 wrap");
    end

    // R5: offers while busy are ignored
    cyc(rnd_d(), 1'b1, 9'h008, "R7");
    for (int n = 0; n < 5; n++) cyc(rnd_d(), 1'b0, 9'h041, "R5");
    cyc(rnd_d(), 1'b0, 9'h001, "R5");

    // R6: two columns refused, mapping held; R7 clears the flag
    cyc(rnd_d(), 1'b1, 9'h081, "R6");
    cyc(rnd_d(), 1'b0, '0,     "R6");
    cyc(rnd_d(), 1'b1, 9'h1FF, "R6");
    cyc(rnd_d(), 1'b1, 9'h000, "R7");
    cyc(rnd_d(), 1'b0, '0,     "R9");
    cyc(rnd_d(), 1'b1, 9'h002, "R7");

    // R8: map offers and data on the same edges, random mix
    for (int n = 0; n < 400; n++)
      cyc(rnd_d(), 1'($urandom % 2), rnd_map(), "R8");

    // R8: back-to-back single-column moves with data every cycle
    for (int f = NL; f >= 0; f--) begin
      logic [NCOL-1:0] m;
      m = '0;
      m[f] = 1'b1;
      cyc(rnd_d(), 1'b1, m, "R8 sweep");
    end

    summary();
    $finish;
  end
endmodule